// File: doc/BRIEF.md
# Selectable Clock Output Generator

This block produces the signal for an external clock pin. It picks one of three internal clocks: a core clock, an oscillator clock, or the system clock divided by a programmable factor. Five plain configuration inputs control it. One bit switches the output on and off. Two bits choose the source. A 3-bit field sets the divide factor. One more bit adds a final divide-by-two toggle stage that gives an exact 50% duty cycle on the divided path.

The block runs on the system clock `clk`. The core and oscillator clocks arrive as sampled levels that are synchronous to `clk`, and each high or low phase lasts at least two `clk` cycles. A registered copy of the selected level drives the pin. The one exception is the undivided pass-through setting, which gates `clk` itself through a flop clocked on the falling edge. Enable, disable and configuration changes only take effect at period boundaries, so the pin never shows a shortened high phase.

Top module: `clkout_sel_gen`

## Requirements
- R1: After a synchronous active-low reset, `clk_out` is low and stays low until `out_en` is set.
- R2: With `sel_hi` = 0, `clk_out` follows `core_clk_i` one `clk` cycle later, whatever `sel_lo` holds.
- R3: With `sel_hi` = 1 and `sel_lo` = 0, `clk_out` follows `osc_clk_i` one `clk` cycle later.
- R4: With both select bits at 1 and `tgl_en` = 0, `div_sel` codes 0..7 choose n = 1, 2, 3, 4, 6, 8, 10, 12. Code 0 passes `clk` through, high in its high half-cycle. For n ≥ 2 the output period is n cycles, with floor(n/2) cycles high and the rest low.
- R5: With both select bits at 1 and `tgl_en` = 1, the output period is 2n cycles, with exactly n cycles high and n cycles low, for every code.
- R6: `tgl_en` has no effect while the core or oscillator clock is selected.
- R7: With `out_en` = 0, `clk_out` settles low and stays low.
- R8: Setting or clearing `out_en` at any time never shortens a high phase. Every high phase on the pin has the full length of the active setting.
- R9: A change of select bits, `div_sel` or `tgl_en` is applied at the end of the current output period, and the divider and toggle stage restart there. Every high phase has either the old length or the new one, and after the change the new period holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the input of the divider |
| rst_n | input | 1 | Synchronous active-low reset |
| core_clk_i | input | 1 | Sampled core clock level |
| osc_clk_i | input | 1 | Sampled oscillator clock level |
| out_en | input | 1 | Output enable |
| sel_hi | input | 1 | Upper source-select bit (0 selects the core clock) |
| sel_lo | input | 1 | Lower source-select bit (0 selects oscillator, 1 selects divided system clock) |
| div_sel | input | 3 | Divide-factor code |
| tgl_en | input | 1 | Enables the divide-by-two toggle stage on the divided path |
| clk_out | output | 1 | Clock to the output pad |

## Verification
The faults that matter here show up as the wrong high or low run lengths on `clk_out`. A divider counter that misses its wrap point stretches or shortens a phase within one output period. A toggle flop that does not flip breaks the 50% duty cycle on the next period. An enable or configuration boundary taken at the wrong time leaves a shortened high phase right at the change. The bench samples the pin twice per `clk` cycle and measures every run. A bad run therefore shows within at most two output periods of its cause.

// File: rtl/clkout_pkg.sv
// Package: clkout_pkg
// Shared widths, configuration struct, source decode and divide-factor map
// for the selectable clock output generator. Assumes a 3-bit divider code.
package clkout_pkg;

    localparam int DSEL_W = 3;  // width of the divide-factor code
    localparam int N_W    = 4;  // width able to hold the largest factor (12)

    typedef enum logic [1:0] {
        SRC_CORE   = 2'd0,
        SRC_OSC    = 2'd1,
        SRC_SYSDIV = 2'd2
    } co_src_e;

    typedef struct packed {
        logic              sel_hi;
        logic              sel_lo;
        logic [DSEL_W-1:0] div_sel;
        logic              tgl;
    } co_cfg_t;

    // Priority decode: the upper bit alone selects the core clock.
    function automatic co_src_e decode_src(input co_cfg_t c);
        if (!c.sel_hi)      return SRC_CORE;
        else if (!c.sel_lo) return SRC_OSC;
        else                return SRC_SYSDIV;
    endfunction

    // Codes 0..3 give 1..4; codes 4..7 give 6, 8, 10, 12.
    function automatic logic [N_W-1:0] div_factor(input logic [DSEL_W-1:0] code);
        logic [N_W-1:0] c;
        c = N_W'(code);
        if (code < DSEL_W'(4)) return c + N_W'(1);
        else                   return (c - N_W'(1)) << 1;
    endfunction

endpackage

// File: rtl/clkout_divider.sv
// Module: clkout_divider
// Counts system clock cycles modulo n and runs the optional divide-by-two
// toggle stage. A restart puts both at the start of a fresh period: counter
// at 0 and toggle flop high. The level it offers for the next cycle uses the
// "next" configuration, so that a restart and a new setting line up.
// Assumes n_cur >= 1 and that n_cur changes only together with a restart.
module clkout_divider #(
    parameter int CNT_W = clkout_pkg::N_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] n_cur,
    input  logic             tgl_cur,
    input  logic [CNT_W-1:0] n_nxt,
    input  logic             tgl_nxt,
    output logic             lvl_nxt,
    output logic             period_end
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tgl_q, tgl_d;
    logic             wrap;
    logic [CNT_W-1:0] half_nxt;

    // Next counter and toggle state; restart jumps to the period start.
    always_comb begin
        wrap = (cnt_q == n_cur - CNT_W'(1));
        if (restart) begin
            cnt_d = '0;
            tgl_d = 1'b1;
        end else if (wrap) begin
            cnt_d = '0;
            tgl_d = ~tgl_q;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
            tgl_d = tgl_q;
        end
    end

    // Level of the next state and end-of-period flag of the current state.
    always_comb begin
        half_nxt   = n_nxt >> 1;
        lvl_nxt    = tgl_nxt ? tgl_d : (cnt_d < half_nxt);
        period_end = tgl_cur ? (wrap && !tgl_q) : wrap;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgl_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            tgl_q <= tgl_d;
        end
    end

    // The counter never reaches the active factor.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < n_cur);

    // The toggle flop flips at every wrap when no restart intervenes.
    assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && wrap) |=> (tgl_q != $past(tgl_q)));

endmodule

// File: rtl/clkout_gate.sv
// Module: clkout_gate
// Synchronizes the output enable to period boundaries and drives the pin.
// The enable turns on at once (the caller restarts the generator then). It
// turns off only when stop_ok marks a boundary. A registered level drives
// the pin, except in pass-through mode, where clk is gated by a flop on the
// falling edge so that the gate only moves while clk is low.
module clkout_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic stop_ok,
    input  logic lvl_cand,
    input  logic pass_cand,
    output logic en_act,
    output logic lvl_o,
    output logic clk_out
);

    logic en_q, en_nxt;
    logic lvl_q, pass_q, gate_q;

    // Enable request held until a clean stop point.
    always_comb begin
        en_nxt = en_q ? (cfg_en || !stop_ok) : cfg_en;
    end

    // Registered enable, output level and pass-through request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lvl_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            en_q   <= en_nxt;
            lvl_q  <= en_nxt && lvl_cand;
            pass_q <= en_nxt && pass_cand;
        end
    end

    // Falling-edge gate for the undivided clock.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= pass_q;
    end

    assign en_act  = en_q;
    assign lvl_o   = lvl_q;
    assign clk_out = lvl_q | (clk & gate_q);

    // When inactive, nothing reaches the pin.
    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!lvl_q && !pass_q));

    // The pass-through and registered paths never drive at the same time.
    assert_pass_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q |-> !lvl_q);

endmodule

// File: rtl/clkout_sel_gen.sv
// Module: clkout_sel_gen (top)
// Selects the core clock, the oscillator clock or the divided system clock
// for the clock output pin. Configuration is held in an active copy that
// loads at period boundaries, or at any time while the output is off.
// Assumes the core and oscillator levels are synchronous to clk, with each
// phase lasting at least two cycles.
module clkout_sel_gen #(
    parameter int DSEL_W = clkout_pkg::DSEL_W,
    parameter int CNT_W  = clkout_pkg::N_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_clk_i,
    input  logic              osc_clk_i,
    input  logic              out_en,
    input  logic              sel_hi,
    input  logic              sel_lo,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic              tgl_en,
    output logic              clk_out
);
    import clkout_pkg::*;

    co_cfg_t          cfg_in, act_q, use_cfg;
    co_src_e          src_act, src_use;
    logic             src_lvl_act, src_lvl_use;
    logic             en_act, lvl_q;
    logic             period_end, div_nxt;
    logic             at_boundary, load, restart, changed;
    logic             src_ok_q, src_ok_eff;
    logic             pass_use, lvl_cand, stop_ok;
    logic [CNT_W-1:0] n_act, n_use;

    // Gather the port fields into one configuration word.
    always_comb begin
        cfg_in.sel_hi  = sel_hi;
        cfg_in.sel_lo  = sel_lo;
        cfg_in.div_sel = div_sel;
        cfg_in.tgl     = tgl_en;
    end

    // Decode of the active setting and the period boundary.
    always_comb begin
        src_act     = decode_src(act_q);
        src_lvl_act = (src_act == SRC_CORE) ? core_clk_i : osc_clk_i;
        n_act       = CNT_W'(div_factor(act_q.div_sel));
        changed     = (cfg_in != act_q);
        at_boundary = (src_act != SRC_SYSDIV) ? (!src_lvl_act && !lvl_q) : period_end;
        load        = !en_act || at_boundary;
        restart     = !en_act || (at_boundary && changed);
    end

    // Setting that governs the next cycle, and the candidate pin level.
    always_comb begin
        use_cfg     = load ? cfg_in : act_q;
        src_use     = decode_src(use_cfg);
        src_lvl_use = (src_use == SRC_CORE) ? core_clk_i : osc_clk_i;
        n_use       = CNT_W'(div_factor(use_cfg.div_sel));
        pass_use    = (src_use == SRC_SYSDIV) && (n_use == CNT_W'(1)) && !use_cfg.tgl;
        src_ok_eff  = !restart && src_ok_q;
        lvl_cand    = (src_use == SRC_SYSDIV) ? div_nxt : (src_lvl_use && src_ok_eff);
        stop_ok     = (src_act != SRC_SYSDIV) ? (!src_lvl_act || !src_ok_q) : period_end;
    end

    // Active configuration copy.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= cfg_in;
    end

    // Arms a sampled source only after it has been seen low, so no partial high phase passes.
    always_ff @(posedge clk) begin
        if (!rst_n)       src_ok_q <= 1'b0;
        else if (restart) src_ok_q <= 1'b0;
        else              src_ok_q <= src_ok_q || !src_lvl_use;
    end

    clkout_divider #(.CNT_W(CNT_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .n_cur      (n_act),
        .tgl_cur    (act_q.tgl),
        .n_nxt      (n_use),
        .tgl_nxt    (use_cfg.tgl),
        .lvl_nxt    (div_nxt),
        .period_end (period_end)
    );

    clkout_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (out_en),
        .stop_ok   (stop_ok),
        .lvl_cand  (lvl_cand),
        .pass_cand (pass_use),
        .en_act    (en_act),
        .lvl_o     (lvl_q),
        .clk_out   (clk_out)
    );

    // A rising output on the core path was preceded by a high core sample.
    assert_core_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl_q) && src_act == SRC_CORE) |-> $past(core_clk_i));

    // A rising output on the oscillator path was preceded by a high oscillator sample.
    assert_osc_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl_q) && src_act == SRC_OSC) |-> $past(osc_clk_i));

    // The active setting only moves at a load point.
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

    // On the divided path the enable drops only at the end of a period.
    assert_stop_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_act) && $past(src_act) == SRC_SYSDIV) |-> $past(period_end));

endmodule

// File: tb/clkout_sel_gen_tb.sv
// Directed bench: the pin is sampled 5 ns after every clk edge (half-cycle
// resolution) and high/low run lengths are compared with values derived
// from the requirements.
module clkout_sel_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_clk_i, osc_clk_i;
    logic       out_en = 1'b0, sel_hi = 1'b0, sel_lo = 1'b0, tgl_en = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       clk_out;
    int         n_vec = 0, n_bad = 0;
    int         core_cnt, osc_cnt;
    bit         done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    clkout_sel_gen u_dut (
        .clk(clk), .rst_n(rst_n), .core_clk_i(core_clk_i), .osc_clk_i(osc_clk_i),
        .out_en(out_en), .sel_hi(sel_hi), .sel_lo(sel_lo), .div_sel(div_sel),
        .tgl_en(tgl_en), .clk_out(clk_out)
    );

    // Source models: core 3 high / 3 low cycles, oscillator 4 high / 6 low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_cnt <= 0; osc_cnt <= 0;
        end else begin
            core_cnt <= (core_cnt == 5) ? 0 : core_cnt + 1;
            osc_cnt  <= (osc_cnt == 9) ? 0 : osc_cnt + 1;
        end
    end
    assign core_clk_i = (core_cnt < 3);
    assign osc_clk_i  = (osc_cnt < 4);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sample(output logic v);
        @(clk);
        #5;
        v = clk_out;
    endtask

    function automatic int nval(input int code);
        return (code < 4) ? code + 1 : 2 * (code - 1);
    endfunction

    task automatic set_cfg(input bit en, input bit hi, input bit lo, input int dv, input bit tg);
        out_en = en; sel_hi = hi; sel_lo = lo; div_sel = 3'(dv); tgl_en = tg;
    endtask

    // Measure nper full periods; eh/el are in half-cycles.
    task automatic measure(input int eh, input int el, input int nper, input string tag);
        logic v;
        int   g;
        g = 0;
        do begin sample(v); g++; end while (v !== 1'b0 && g < 400);
        do begin sample(v); g++; end while (v !== 1'b1 && g < 800);
        for (int p = 0; p < nper; p++) begin
            int h, l;
            h = 1; l = 0;
            sample(v);
            while (v === 1'b1 && h < 300) begin h++; sample(v); end
            l = 1;
            sample(v);
            while (v === 1'b0 && l < 300) begin l++; sample(v); end
            check(h == eh, {tag, " high run"}, h, eh);
            check(l == el, {tag, " low run"}, l, el);
        end
    endtask

    task automatic t_reset_R1();
        int highs;
        logic v;
        highs = 0;
        for (int i = 0; i < 60; i++) begin sample(v); if (v !== 1'b0) highs++; end
        check(highs == 0, "R1 output low after reset", highs, 0);
    endtask

    task automatic t_core_R2();
        set_cfg(1, 0, 0, 5, 0);
        measure(6, 6, 3, "R2 core sel_lo=0");
        set_cfg(1, 0, 1, 5, 0);
        measure(6, 6, 3, "R2 core sel_lo=1");
    endtask

    task automatic t_osc_R3();
        set_cfg(1, 1, 0, 2, 0);
        measure(8, 12, 3, "R3 oscillator");
    endtask

    task automatic t_div_R4();
        for (int c = 0; c < 8; c++) begin
            int n;
            n = nval(c);
            set_cfg(1, 1, 1, c, 0);
            if (n == 1) measure(1, 1, 4, "R4 pass-through");
            else        measure(2 * (n / 2), 2 * (n - n / 2), 2, $sformatf("R4 code %0d", c));
        end
    endtask

    task automatic t_toggle_R5();
        for (int c = 0; c < 8; c++) begin
            int n;
            n = nval(c);
            set_cfg(1, 1, 1, c, 1);
            measure(2 * n, 2 * n, 2, $sformatf("R5 toggle code %0d", c));
        end
    endtask

    task automatic t_tgl_ignored_R6();
        set_cfg(1, 0, 1, 7, 1);
        measure(6, 6, 3, "R6 core with toggle");
        set_cfg(1, 1, 0, 7, 1);
        measure(8, 12, 3, "R6 oscillator with toggle");
    endtask

    task automatic t_disable_R7();
        int highs;
        logic v;
        set_cfg(0, 1, 1, 3, 0);
        repeat (60) sample(v);
        highs = 0;
        for (int i = 0; i < 120; i++) begin sample(v); if (v !== 1'b0) highs++; end
        check(highs == 0, "R7 output low while disabled", highs, 0);
    endtask

    // Toggle the enable at uneven points; every finished high run must be full.
    task automatic t_no_runt_R8(input bit hi, input int dv, input int eh, input string tag);
        logic v, pv;
        int   run;
        bit   armed;
        set_cfg(1, hi, 1, dv, 0);
        pv = 1'b1; run = 0; armed = 1'b0;
        for (int i = 0; i < 900; i++) begin
            sample(v);
            if (i % 53 == 17) out_en = ~out_en;
            if (v === 1'b1) run++;
            if (v === 1'b0 && pv === 1'b1 && armed) check(run == eh, tag, run, eh);
            if (v === 1'b0) begin armed = 1'b1; run = 0; end
            pv = v;
        end
        out_en = 1'b1;
    endtask

    // Change the setting mid-period; high runs must be old or new length.
    task automatic t_change_R9(input bit hi2, input int dv2, input int eh1, input int eh2,
                               input int el2, input string tag);
        logic v, pv;
        int   run;
        bit   armed;
        set_cfg(1, 1, 1, 3, 0);
        measure(eh1, eh1, 1, {tag, " before"});
        pv = 1'b1; run = 0; armed = 1'b0;
        for (int i = 0; i < 80; i++) begin
            sample(v);
            if (i == 3) begin sel_hi = hi2; div_sel = 3'(dv2); end
            if (v === 1'b1) run++;
            if (v === 1'b0 && pv === 1'b1 && armed)
                check(run == eh1 || run == eh2, {tag, " transition"}, run, eh2);
            if (v === 1'b0) begin armed = 1'b1; run = 0; end
            pv = v;
        end
        measure(eh2, el2, 2, {tag, " after"});
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #5 rst_n = 1'b1;
        t_reset_R1();
        t_core_R2();
        t_osc_R3();
        t_div_R4();
        t_toggle_R5();
        t_tgl_ignored_R6();
        t_disable_R7();
        t_no_runt_R8(1'b1, 4, 6, "R8 divided n=6 enable toggling");
        t_no_runt_R8(1'b0, 0, 6, "R8 core enable toggling");
        t_no_runt_R8(1'b1, 0, 1, "R8 pass-through enable toggling");
        t_change_R9(1'b1, 5, 4, 8, 8, "R9 n=4 to n=8");
        t_change_R9(1'b0, 3, 4, 6, 6, "R9 n=4 to core");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule